// File: doc/BRIEF.md
# Oscillator Failure Detector with Clock Fallback

This block watches an external high-speed oscillator clock from a separate, always-running internal reference clock. The monitored clock is brought into the reference domain through a synchronizer. A counter measures how many reference cycles pass between detected rising edges. If the monitored clock stays still for too long while monitoring is enabled, the block declares a failure and takes recovery action.

On a failure the block makes the oscillator enable output inactive. It forces the system clock selection to the internal high-speed oscillator. It also turns the PLL off when the PLL was fed from the external oscillator and was driving the system clock. A sticky status flag records the event. A non-maskable interrupt request is raised whenever that flag is set and the interrupt enable is on.

The recovery state stays in place until software clears the flag by writing one and then re-enables the oscillator (a 0 to 1 transition of its enable request). Software is expected to turn monitoring on only after the oscillator has had time to start, and to turn it off before stopping the oscillator on purpose.

Top module: `osc_fail_guard`

## Requirements
- R1: After reset the status flag and the NMI request are 0, no fallback is in force, `osc_en` equals `osc_en_req`, `pll_en` equals `pll_en_req` and `sys_sel` equals `sys_sel_req`.
- R2: While `mon_en` is 1 and detected rising edges of `mon_clk` are fewer than TIMEOUT reference cycles apart, no failure is declared.
- R3: While `mon_en` is 1, TIMEOUT consecutive reference cycles without a detected rising edge (after a SYNC_STAGES-flop synchronizer) declare a failure and set `stuck_flag`.
- R4: While `mon_en` is 0, no failure is declared, however long `mon_clk` is still.
- R5: During fallback, `osc_en` is held at 0 whatever `osc_en_req` is.
- R6: During fallback, `sys_sel` is forced to 2'b00, the internal oscillator. The select encoding is 2'b00 internal oscillator, 2'b01 external oscillator and 2'b10 PLL.
- R7: A failure forces `pll_en` to 0 only if, in the cycle the failure is declared, `pll_src_ext` is 1 and `sys_sel_req` is 2'b10. Otherwise `pll_en` keeps following `pll_en_req`.
- R8: `nmi_req` is a level that is 1 exactly while `stuck_flag` and `irq_en` are both 1.
- R9: A one-cycle pulse on `flag_clr` (a write of one) clears `stuck_flag`. If a failure is declared in the same cycle, the failure wins.
- R10: Fallback ends only once `stuck_flag` is 0 and `osc_en_req` then rises from 0 to 1. Clearing the flag alone, or toggling the request while the flag is still set, does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal reference clock that runs the block |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_clk | input | 1 | Monitored external oscillator clock (asynchronous) |
| mon_en | input | 1 | Monitoring enable |
| irq_en | input | 1 | Failure interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear pulse for the status flag |
| osc_en_req | input | 1 | Software enable request for the external oscillator |
| pll_en_req | input | 1 | Software enable request for the PLL |
| pll_src_ext | input | 1 | 1 when the PLL takes its input from the external oscillator |
| sys_sel_req | input | 2 | Software system clock select (00 internal, 01 external, 10 PLL) |
| osc_en | output | 1 | Effective external oscillator enable |
| pll_en | output | 1 | Effective PLL enable |
| sys_sel | output | 2 | Effective system clock select |
| stuck_flag | output | 1 | Sticky oscillator failure flag |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with TIMEOUT set to 8 and the default two-flop synchronizer. With this setting a monitored clock with a 4-cycle or 6-cycle period sits safely inside the window, a 12-cycle period falls outside it, and a stopped clock trips the detector within a few tens of cycles. That makes the edge-spacing boundary, and every PLL-cascade and interrupt-enable combination, cheap to reach.

// File: rtl/ofg_pkg.sv
// Package: shared clock-select encoding for the oscillator failure detector.
// Assumes a two-bit system clock select field decoded by the clock mux.
package ofg_pkg;
    typedef enum logic [1:0] {
        SEL_INT = 2'b00,
        SEL_EXT = 2'b01,
        SEL_PLL = 2'b10
    } sysclk_sel_e;
endpackage

// File: rtl/ofg_edge_sync.sv
// Module: brings the asynchronous monitored clock into the reference domain
// through a chain of flops and reports one-cycle rising-edge pulses.
// Assumes the monitored clock is slower than half the reference rate, so
// every rising edge is seen at least once by the chain.
module ofg_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic mon_clk,
    output logic rise_seen
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    // First stage samples the asynchronous input
    always_ff @(posedge clk_ref) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= mon_clk;
    end

    genvar gi;
    generate
        for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_stage
            // Each later stage resamples the previous one
            always_ff @(posedge clk_ref) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    // Holds the previous synchronized level for edge detection
    always_ff @(posedge clk_ref) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[SYNC_STAGES-1];
    end

    assign rise_seen = chain[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/ofg_stall_timer.sv
// Module: counts reference cycles since the last detected rising edge and
// flags a stall on the TIMEOUT-th consecutive cycle without one.
// Assumes TIMEOUT >= 2; the count restarts whenever monitoring is inactive.
module ofg_stall_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic active,
    input  logic rise_seen,
    output logic stall
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] gap_cnt;

    // Gap counter: cleared by an edge or inactivity, otherwise advances
    always_ff @(posedge clk_ref) begin
        if (!rst_n)                 gap_cnt <= '0;
        else if (!active || rise_seen) gap_cnt <= '0;
        else if (gap_cnt != LAST)   gap_cnt <= gap_cnt + 1'b1;
    end

    assign stall = active & ~rise_seen & (gap_cnt == LAST);
endmodule

// File: rtl/ofg_fallback_ctrl.sv
// Module: holds the sticky failure flag, the fallback state and the PLL
// cascade decision, and produces the effective enables, select and NMI.
// Assumes flag_clr is a single-cycle write pulse in the reference domain.
module ofg_fallback_ctrl
    import ofg_pkg::*;
(
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       fail,
    input  logic       irq_en,
    input  logic       flag_clr,
    input  logic       osc_en_req,
    input  logic       pll_en_req,
    input  logic       pll_src_ext,
    input  logic [1:0] sys_sel_req,
    output logic       in_fallback,
    output logic       osc_en,
    output logic       pll_en,
    output logic [1:0] sys_sel,
    output logic       stuck_flag,
    output logic       nmi_req
);
    logic flag_q;
    logic fb_q;
    logic pll_kill_q;
    logic osc_req_q;
    logic osc_req_rise;
    logic release_fb;
    logic cascade;

    assign osc_req_rise = osc_en_req & ~osc_req_q;
    assign release_fb   = fb_q & ~flag_q & osc_req_rise;
    assign cascade      = pll_src_ext & (sysclk_sel_e'(sys_sel_req) == SEL_PLL);

    // Remembers last request level to spot a re-enable
    always_ff @(posedge clk_ref) begin
        if (!rst_n) osc_req_q <= 1'b0;
        else        osc_req_q <= osc_en_req;
    end

    // Sticky flag: set by failure (priority), cleared by write-one
    always_ff @(posedge clk_ref) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (fail)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Fallback state: entered on failure, left on clear-then-re-enable
    always_ff @(posedge clk_ref) begin
        if (!rst_n)          fb_q <= 1'b0;
        else if (fail)       fb_q <= 1'b1;
        else if (release_fb) fb_q <= 1'b0;
    end

    // PLL cascade: latched at failure when PLL is fed by and drives from the oscillator
    always_ff @(posedge clk_ref) begin
        if (!rst_n)          pll_kill_q <= 1'b0;
        else if (fail)       pll_kill_q <= cascade;
        else if (release_fb) pll_kill_q <= 1'b0;
    end

    // Effective outputs under fallback
    always_comb begin
        in_fallback = fb_q;
        osc_en      = osc_en_req & ~fb_q;
        pll_en      = pll_en_req & ~pll_kill_q;
        sys_sel     = fb_q ? SEL_INT : sys_sel_req;
        stuck_flag  = flag_q;
        nmi_req     = flag_q & irq_en;
    end
endmodule

// File: rtl/osc_fail_guard.sv
// Module: top of the oscillator failure detector. Synchronizes the monitored
// clock, times the gaps between its edges and applies the fallback.
// Assumes clk_ref is independent of mon_clk and always running.
module osc_fail_guard #(
    parameter int TIMEOUT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       mon_clk,
    input  logic       mon_en,
    input  logic       irq_en,
    input  logic       flag_clr,
    input  logic       osc_en_req,
    input  logic       pll_en_req,
    input  logic       pll_src_ext,
    input  logic [1:0] sys_sel_req,
    output logic       osc_en,
    output logic       pll_en,
    output logic [1:0] sys_sel,
    output logic       stuck_flag,
    output logic       nmi_req
);
    logic rise_seen;
    logic stall;
    logic in_fallback;
    logic watch_active;

    // Monitoring pauses during fallback so one failure is reported once
    assign watch_active = mon_en & ~in_fallback;

    ofg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .mon_clk   (mon_clk),
        .rise_seen (rise_seen)
    );

    ofg_stall_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .active    (watch_active),
        .rise_seen (rise_seen),
        .stall     (stall)
    );

    ofg_fallback_ctrl u_ctrl (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .fail        (stall),
        .irq_en      (irq_en),
        .flag_clr    (flag_clr),
        .osc_en_req  (osc_en_req),
        .pll_en_req  (pll_en_req),
        .pll_src_ext (pll_src_ext),
        .sys_sel_req (sys_sel_req),
        .in_fallback (in_fallback),
        .osc_en      (osc_en),
        .pll_en      (pll_en),
        .sys_sel     (sys_sel),
        .stuck_flag  (stuck_flag),
        .nmi_req     (nmi_req)
    );
endmodule

// File: rtl/osc_fail_guard_chk.sv
// Module: property checker for osc_fail_guard, attached through bind.
// Assumes only the top-level ports are visible.
module osc_fail_guard_chk (
    input logic       clk_ref,
    input logic       rst_n,
    input logic       mon_en,
    input logic       irq_en,
    input logic       flag_clr,
    input logic       osc_en_req,
    input logic       pll_en_req,
    input logic       pll_src_ext,
    input logic [1:0] sys_sel_req,
    input logic       osc_en,
    input logic       pll_en,
    input logic [1:0] sys_sel,
    input logic       stuck_flag,
    input logic       nmi_req
);
    a_r4_needs_enable: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(stuck_flag) |-> $past(mon_en));

    a_r5_osc_held_off: assert property (@(posedge clk_ref) disable iff (!rst_n)
        stuck_flag |-> !osc_en);

    a_r6_forced_internal: assert property (@(posedge clk_ref) disable iff (!rst_n)
        stuck_flag |-> sys_sel == 2'b00);

    a_r7_pll_cut: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($rose(stuck_flag) && $past(pll_src_ext) && $past(sys_sel_req) == 2'b10) |-> !pll_en);

    a_r7_pll_spared: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($rose(stuck_flag) && !$past(pll_src_ext)) |-> pll_en == pll_en_req);

    a_r8_nmi_gated: assert property (@(posedge clk_ref) disable iff (!rst_n)
        nmi_req |-> (stuck_flag && irq_en));

    a_r9_clear_by_write: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(stuck_flag) |-> $past(flag_clr));

    a_r10_hold_after_clear: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(stuck_flag) |-> sys_sel == 2'b00);
endmodule

bind osc_fail_guard osc_fail_guard_chk u_chk (.*);

// File: tb/osc_fail_guard_test.sv
// Bench: vector table of fallback scenarios, then directed tests.
module osc_fail_guard_test;
    localparam int TO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_clk = 1'b0;
    logic       mon_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       osc_en_req = 1'b1;
    logic       pll_en_req = 1'b1;
    logic       pll_src_ext = 1'b0;
    logic [1:0] sys_sel_req = 2'b01;
    logic       osc_en, pll_en, stuck_flag, nmi_req;
    logic [1:0] sys_sel;

    int checks = 0;
    int failures = 0;
    bit mon_run = 1'b0;
    int mon_half = 2;
    bit done = 1'b0;

    // {pll_src_ext, sys_sel_req[1:0], irq_en, exp_pll_en, exp_nmi}
    localparam logic [5:0] VEC [4] = '{
        6'b1_10_1_0_1,
        6'b0_10_0_1_0,
        6'b1_01_1_1_1,
        6'b1_00_0_1_0
    };

    osc_fail_guard #(.TIMEOUT(TO)) uut (
        .clk_ref(clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_en(mon_en),
        .irq_en(irq_en), .flag_clr(flag_clr), .osc_en_req(osc_en_req),
        .pll_en_req(pll_en_req), .pll_src_ext(pll_src_ext),
        .sys_sel_req(sys_sel_req), .osc_en(osc_en), .pll_en(pll_en),
        .sys_sel(sys_sel), .stuck_flag(stuck_flag), .nmi_req(nmi_req)
    );

    always #2 clk = ~clk;

    // Monitored clock generator, half period counted in reference cycles
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (mon_run) begin
                ph++;
                if (ph >= mon_half) begin
                    ph = 0;
                    mon_clk = ~mon_clk;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Clear the flag and re-enable the oscillator to leave fallback
    task automatic rearm();
        mon_en = 1'b0;
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        osc_en_req = 1'b0;
        tick(1);
        osc_en_req = 1'b1;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 flag", {7'b0, stuck_flag}, 8'd0);
        chk("R1 nmi", {7'b0, nmi_req}, 8'd0);
        chk("R1 osc_en", {7'b0, osc_en}, 8'd1);
        chk("R1 pll_en", {7'b0, pll_en}, 8'd1);
        chk("R1 sys_sel", {6'b0, sys_sel}, 8'd1);

        foreach (VEC[i]) begin
            rearm();
            pll_src_ext = VEC[i][5];
            sys_sel_req = VEC[i][4:3];
            irq_en      = VEC[i][2];
            mon_half = 2;
            mon_run = 1'b1;
            tick(8);
            mon_en = 1'b1;
            tick(30);
            chk("R2 no fail on running clock", {7'b0, stuck_flag}, 8'd0);
            chk("R2 select passes", {6'b0, sys_sel}, {6'b0, VEC[i][4:3]});
            chk("R2 osc_en passes", {7'b0, osc_en}, 8'd1);
            mon_run = 1'b0;
            tick(2);
            chk("R3 not yet failed", {7'b0, stuck_flag}, 8'd0);
            tick(4 + TO + 8);
            chk("R3 failure flagged", {7'b0, stuck_flag}, 8'd1);
            chk("R5 osc_en forced off", {7'b0, osc_en}, 8'd0);
            chk("R6 select forced internal", {6'b0, sys_sel}, 8'd0);
            chk("R7 pll_en cascade", {7'b0, pll_en}, {7'b0, VEC[i][1]});
            chk("R8 nmi level", {7'b0, nmi_req}, {7'b0, VEC[i][0]});
            irq_en = ~irq_en;
            tick(1);
            chk("R8 nmi follows enable", {7'b0, nmi_req}, {7'b0, ~VEC[i][0]});
        end

        // R4: monitor disabled, stopped clock never fails
        rearm();
        irq_en = 1'b1;
        pll_src_ext = 1'b1;
        sys_sel_req = 2'b10;
        mon_run = 1'b0;
        tick(40);
        chk("R4 no fail while disabled", {7'b0, stuck_flag}, 8'd0);
        chk("R4 osc_en untouched", {7'b0, osc_en}, 8'd1);
        chk("R4 pll_en untouched", {7'b0, pll_en}, 8'd1);

        // R2/R3 boundary: 6-cycle period stays inside the window, 12 does not
        mon_half = 3;
        mon_run = 1'b1;
        tick(10);
        mon_en = 1'b1;
        tick(60);
        chk("R2 period below timeout", {7'b0, stuck_flag}, 8'd0);
        mon_half = 6;
        tick(60);
        chk("R3 period above timeout", {7'b0, stuck_flag}, 8'd1);
        mon_run = 1'b0;

        // R10: re-enable request while flag set does not release
        osc_en_req = 1'b0;
        tick(1);
        osc_en_req = 1'b1;
        tick(2);
        chk("R10 held while flag set", {7'b0, osc_en}, 8'd0);
        // R9: write-one clears the flag
        mon_en = 1'b0;
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        tick(1);
        chk("R9 flag cleared", {7'b0, stuck_flag}, 8'd0);
        chk("R9 nmi dropped", {7'b0, nmi_req}, 8'd0);
        chk("R10 select still forced", {6'b0, sys_sel}, 8'd0);
        chk("R10 osc still off", {7'b0, osc_en}, 8'd0);
        chk("R10 pll still off", {7'b0, pll_en}, 8'd0);
        osc_en_req = 1'b0;
        tick(1);
        osc_en_req = 1'b1;
        tick(2);
        chk("R10 released osc_en", {7'b0, osc_en}, 8'd1);
        chk("R10 released select", {6'b0, sys_sel}, 8'd2);
        chk("R10 released pll_en", {7'b0, pll_en}, 8'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule